// File: doc/BRIEF.md
# Adder-Free Coin Vending State Machine

This block is the control core of a drink dispenser. It watches three coin strobes, one for each accepted coin value (5, 10 and 25 cents), and takes at most one coin per clock cycle. It does not keep a running sum in a register that an adder updates. Each reachable credit level, from 0 to 40 cents in 5-cent steps, is a state of its own. Every state and coin pair leads to a next state and a change value that are written out as fixed entries in a transition table. No arithmetic unit is involved.

The drink costs 45 cents, so it is released as soon as the credit goes above 40 cents. When a coin pushes the credit past that point, the block raises a one-cycle dispense pulse. In that same cycle it shows the overpayment as a count of 5-cent units, and the credit restarts from zero. A cycle in which more than one strobe is high is treated as noise and has no effect. Coin validation and mechanical timing are handled upstream.

Top module: `vend_fsm_top`

## Requirements
- R1: A synchronous active-high reset sets the credit to zero and drives `dispense` and `change` to 0 in the cycle after the reset edge.
- R2: While the credit stays at or below 40 cents, a single coin strobe adds its value (`coin_5` = 5, `coin_10` = 10, `coin_25` = 25 cents) and `dispense` stays low.
- R3: In the cycle after the clock edge that samples a coin taking the credit to 45 cents or more, `dispense` is high for exactly one cycle.
- R4: While `dispense` is high, `change` carries (credit + coin − 45) / 5 as an unsigned binary count of 5-cent units, from 0 to 4.
- R5: `change` is 0 in every cycle in which `dispense` is low.
- R6: After a dispense the credit is zero, so a coin sampled at the next edge counts from zero.
- R7: A cycle with two or more coin strobes high is ignored: the credit is unchanged and no dispense follows.
- R8: A cycle with no coin strobe leaves the credit unchanged and produces no dispense.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst | input | 1 | Synchronous reset, active high |
| coin_5 | input | 1 | Strobe for a 5-cent coin in this cycle |
| coin_10 | input | 1 | Strobe for a 10-cent coin in this cycle |
| coin_25 | input | 1 | Strobe for a 25-cent coin in this cycle |
| dispense | output | 1 | One-cycle pulse that releases a drink |
| change | output | CHG_W (3) | Overpayment in 5-cent units, valid with `dispense` |

## Verification
The bench drives the block with these coin sequences:
- Nine single 5-cent coins, which reach the price exactly, with zero change.
- Runs of 10-cent coins, which pass the price with 5 cents over.
- Two 25-cent coins, which overshoot by one unit.
- Four 10-cent coins followed by a 25-cent coin, which gives the maximum change of four units.

Between these runs it inserts idle cycles and cycles with two or three strobes high. An error in the state that holds the credit then shows up in the timing or the change of a later dispense. A coin placed in the dispense cycle shows whether the credit really restarts from zero. A reset in the middle of a sequence shows whether partial credit is discarded.

// File: rtl/vend_pkg.sv
package vend_pkg;

    localparam int UNIT_CENTS = 5;
    localparam int PRICE_UNITS = 9;                 // 45 cents
    localparam int MAX_IDLE_UNITS = PRICE_UNITS - 1; // 40 cents
    localparam int CREDIT_W = $clog2(PRICE_UNITS);
    localparam int CHG_W = 3;

    typedef enum logic [CREDIT_W-1:0] {
        CR_00 = 4'd0,
        CR_05 = 4'd1,
        CR_10 = 4'd2,
        CR_15 = 4'd3,
        CR_20 = 4'd4,
        CR_25 = 4'd5,
        CR_30 = 4'd6,
        CR_35 = 4'd7,
        CR_40 = 4'd8
    } credit_e;

    typedef enum logic [2:0] {
        COIN_NONE,
        COIN_05,
        COIN_10,
        COIN_25,
        COIN_BAD
    } coin_e;

    typedef struct packed {
        credit_e          nxt;
        logic             vend;
        logic [CHG_W-1:0] chg;
    } step_t;

    function automatic step_t go_to(credit_e s);
        step_t r;
        r.nxt  = s;
        r.vend = 1'b0;
        r.chg  = '0;
        return r;
    endfunction

    function automatic step_t vend_with(logic [CHG_W-1:0] units);
        step_t r;
        r.nxt  = CR_00;
        r.vend = 1'b1;
        r.chg  = units;
        return r;
    endfunction

    // Fixed transition table: every (credit, coin) pair is spelled out.
    function automatic step_t take_coin(credit_e cur, coin_e coin);
        step_t r;
        r = go_to(cur);
        if (coin == COIN_05 || coin == COIN_10 || coin == COIN_25) begin
            case (cur)
                CR_00: case (coin)
                    COIN_05: r = go_to(CR_05);
                    COIN_10: r = go_to(CR_10);
                    default: r = go_to(CR_25);
                endcase
                CR_05: case (coin)
                    COIN_05: r = go_to(CR_10);
                    COIN_10: r = go_to(CR_15);
                    default: r = go_to(CR_30);
                endcase
                CR_10: case (coin)
                    COIN_05: r = go_to(CR_15);
                    COIN_10: r = go_to(CR_20);
                    default: r = go_to(CR_35);
                endcase
                CR_15: case (coin)
                    COIN_05: r = go_to(CR_20);
                    COIN_10: r = go_to(CR_25);
                    default: r = go_to(CR_40);
                endcase
                CR_20: case (coin)
                    COIN_05: r = go_to(CR_25);
                    COIN_10: r = go_to(CR_30);
                    default: r = vend_with(3'd0);
                endcase
                CR_25: case (coin)
                    COIN_05: r = go_to(CR_30);
                    COIN_10: r = go_to(CR_35);
                    default: r = vend_with(3'd1);
                endcase
                CR_30: case (coin)
                    COIN_05: r = go_to(CR_35);
                    COIN_10: r = go_to(CR_40);
                    default: r = vend_with(3'd2);
                endcase
                CR_35: case (coin)
                    COIN_05: r = go_to(CR_40);
                    COIN_10: r = vend_with(3'd0);
                    default: r = vend_with(3'd3);
                endcase
                CR_40: case (coin)
                    COIN_05: r = vend_with(3'd0);
                    COIN_10: r = vend_with(3'd1);
                    default: r = vend_with(3'd4);
                endcase
                default: r = go_to(CR_00);
            endcase
        end
        return r;
    endfunction

endpackage

// File: rtl/vend_coin_decode.sv
module vend_coin_decode
    import vend_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  str_5,
    input  logic  str_10,
    input  logic  str_25,
    output coin_e coin
);

    always_comb begin
        case ({str_25, str_10, str_5})
            3'b000:  coin = COIN_NONE;
            3'b001:  coin = COIN_05;
            3'b010:  coin = COIN_10;
            3'b100:  coin = COIN_25;
            default: coin = COIN_BAD;
        endcase
    end

    // R7: any multi-hot strobe pattern is flagged as a rejected input
    p_multi_hot_rejected_r7: assert property (@(posedge clk) disable iff (rst)
        ($countones({str_25, str_10, str_5}) > 1) |-> (coin == COIN_BAD));

    // R2: a lone strobe is always decoded as a coin
    p_single_accepted_r2: assert property (@(posedge clk) disable iff (rst)
        ($onehot0({str_25, str_10, str_5}) && (str_5 || str_10 || str_25))
        |-> (coin != COIN_BAD && coin != COIN_NONE));

endmodule

// File: rtl/vend_credit_fsm.sv
module vend_credit_fsm
    import vend_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  coin_e   coin,
    output credit_e credit_q,
    output step_t   step
);

    always_comb step = take_coin(credit_q, coin);

    always_ff @(posedge clk) begin
        if (rst) credit_q <= CR_00;
        else     credit_q <= step.nxt;
    end

    // R1: reset always lands on the zero-credit state
    p_reset_zero_r1: assert property (@(posedge clk)
        rst |=> (credit_q == CR_00));

    // R7: a rejected pattern leaves the credit untouched
    p_bad_holds_r7: assert property (@(posedge clk) disable iff (rst)
        (coin == COIN_BAD) |=> $stable(credit_q));

    // R8: an idle cycle leaves the credit untouched
    p_idle_holds_r8: assert property (@(posedge clk) disable iff (rst)
        (coin == COIN_NONE) |=> $stable(credit_q));

    // R2: with no vend, credit never drops while a coin is taken
    p_credit_rises_r2: assert property (@(posedge clk) disable iff (rst)
        (coin == COIN_05 && credit_q != CR_40) |=> (credit_q != CR_00));

endmodule

// File: rtl/vend_out_stage.sv
module vend_out_stage
    import vend_pkg::*;
#(
    parameter int OUT_W = CHG_W
) (
    input  logic             clk,
    input  logic             rst,
    input  step_t            step,
    output logic             vend_q,
    output logic [OUT_W-1:0] chg_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            vend_q <= 1'b0;
            chg_q  <= '0;
        end else begin
            vend_q <= step.vend;
            chg_q  <= step.vend ? OUT_W'(step.chg) : '0;
        end
    end

    // R1: outputs are cleared by reset
    p_reset_clear_r1: assert property (@(posedge clk)
        rst |=> (!vend_q && chg_q == '0));

    // R3: a vend pulse never lasts two cycles
    p_single_pulse_r3: assert property (@(posedge clk) disable iff (rst)
        vend_q |=> !vend_q);

    // R4: change never exceeds four units
    p_change_max_r4: assert property (@(posedge clk) disable iff (rst)
        vend_q |-> (chg_q <= OUT_W'(4)));

    // R5: no change without a vend
    p_change_idle_r5: assert property (@(posedge clk) disable iff (rst)
        !vend_q |-> (chg_q == '0));

endmodule

// File: rtl/vend_fsm_top.sv
module vend_fsm_top
    import vend_pkg::*;
#(
    parameter int CHG_BITS = CHG_W
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                coin_5,
    input  logic                coin_10,
    input  logic                coin_25,
    output logic                dispense,
    output logic [CHG_BITS-1:0] change
);

    coin_e   coin;
    credit_e credit_q;
    step_t   step;

    vend_coin_decode u_dec (
        .clk    (clk),
        .rst    (rst),
        .str_5  (coin_5),
        .str_10 (coin_10),
        .str_25 (coin_25),
        .coin   (coin)
    );

    vend_credit_fsm u_fsm (
        .clk      (clk),
        .rst      (rst),
        .coin     (coin),
        .credit_q (credit_q),
        .step     (step)
    );

    vend_out_stage #(.OUT_W(CHG_BITS)) u_out (
        .clk    (clk),
        .rst    (rst),
        .step   (step),
        .vend_q (dispense),
        .chg_q  (change)
    );

    // R6: the credit is zero whenever a drink is being released
    p_vend_zero_r6: assert property (@(posedge clk) disable iff (rst)
        dispense |-> (credit_q == CR_00));

endmodule

// File: tb/tb_vend_fsm_top.sv
module tb_vend_fsm_top;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       coin_5 = 1'b0;
    logic       coin_10 = 1'b0;
    logic       coin_25 = 1'b0;
    logic       dispense;
    logic [2:0] change;

    int vectors = 0;
    int misses  = 0;
    int credit  = 0;   // model credit in cents
    int cycles  = 0;
    bit done    = 1'b0;

    always #2 clk = ~clk;   // 250 MHz

    vend_fsm_top dut (
        .clk      (clk),
        .rst      (rst),
        .coin_5   (coin_5),
        .coin_10  (coin_10),
        .coin_25  (coin_25),
        .dispense (dispense),
        .change   (change)
    );

    task automatic compare(input bit ev, input int ec, input string tag);
        vectors++;
        if (dispense !== ev || int'(change) != ec) begin
            misses++;
            $display("FAIL %s: dispense=%0b change=%0d expected dispense=%0b change=%0d",
                     tag, dispense, change, ev, ec);
        end
    endtask

    // Drive one cycle of strobes, advance the model, check after the edge.
    task automatic step(input bit s5, input bit s10, input bit s25, input string tag);
        bit ev;
        int ec;
        int val;
        int total;
        coin_5 = s5; coin_10 = s10; coin_25 = s25;
        @(posedge clk);
        ev = 1'b0; ec = 0;
        if (rst) begin
            credit = 0;
        end else if (int'(s5) + int'(s10) + int'(s25) == 1) begin
            val   = s5 ? 5 : (s10 ? 10 : 25);
            total = credit + val;
            if (total > 40) begin
                ev = 1'b1;
                ec = (total - 45) / 5;
                credit = 0;
            end else begin
                credit = total;
            end
        end
        @(negedge clk);
        compare(ev, ec, tag);
    endtask

    task automatic reset_cycle(input string tag);
        rst = 1'b1;
        step(1'b0, 1'b0, 1'b0, tag);
        rst = 1'b0;
    endtask

    initial begin : watchdog
        while (!done && cycles < 20000) begin
            @(posedge clk);
            cycles++;
        end
        if (!done) begin
            misses++;
            vectors++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        reset_cycle("R1 reset clears outputs");
        step(0, 0, 0, "R1 idle after reset");

        // Nine 5-cent coins: exact price, no change
        for (int i = 0; i < 8; i++) step(1, 0, 0, "R2 accumulate 5");
        step(1, 0, 0, "R3 R4 vend at 45 change 0");
        step(0, 0, 0, "R3 pulse ends R5 change clear");

        // 25 + 25 = 50
        step(0, 0, 1, "R2 accumulate 25");
        step(0, 0, 0, "R8 idle holds");
        step(0, 0, 1, "R4 vend at 50 change 1");

        // 10 x4 then 25: maximum change
        for (int i = 0; i < 4; i++) step(0, 1, 0, "R2 accumulate 10");
        step(0, 0, 1, "R4 max change 4");

        // Coin in the dispense cycle counts from zero
        for (int i = 0; i < 4; i++) step(0, 1, 0, "R2 accumulate 10");
        step(0, 1, 0, "R4 vend at 50 change 1");
        step(0, 0, 1, "R6 coin after vend from zero");
        step(0, 0, 1, "R6 second 25 vends change 1");

        // Multi-hot cycles are ignored
        step(0, 1, 0, "R2 accumulate 10");
        step(1, 1, 0, "R7 two strobes ignored");
        step(1, 1, 1, "R7 three strobes ignored");
        step(1, 0, 1, "R7 5+25 ignored");
        step(0, 0, 1, "R7 credit kept at 35");
        step(0, 1, 0, "R4 vend at 45 change 0");

        // 35 + 25 = 60, 30 + 25 = 55
        step(0, 1, 0, "R2"); step(0, 0, 1, "R2");
        step(0, 0, 1, "R4 vend at 60 change 3");
        step(0, 0, 1, "R2"); step(1, 0, 0, "R2");
        step(0, 0, 1, "R4 vend at 55 change 2");

        // Reset mid-sequence discards credit
        step(0, 0, 1, "R2");
        reset_cycle("R1 reset mid credit");
        step(0, 0, 1, "R1 credit restarted");
        step(0, 1, 0, "R1 credit restarted");
        step(0, 1, 0, "R3 vend at 45 after reset");

        // Long idle run then a pattern sweep
        for (int i = 0; i < 6; i++) step(0, 0, 0, "R8 idle no vend");
        for (int i = 0; i < 60; i++)
            step(i % 3 == 0, i % 3 == 1, i % 7 == 0, "R2 R3 R4 R7 sweep");

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
        $finish;
    end

endmodule